// File: doc/BRIEF.md
# Transmit Frame Validator and Launcher

This block sends one Ethernet frame that software has already assembled in a 2048-byte transmit buffer, including its preamble, start-of-frame delimiter and trailing frame check sequence. Software triggers a send by writing the total byte count of the buffered frame into a count register. The block then checks the count against a minimum and a maximum length. It reads the eight leading bytes back from the buffer RAM and compares them with the expected preamble pattern. Only when every check holds does it stream the frame body to a byte-stream output. The body is the frame without its first 8 bytes and its last 4 bytes.

Every triggered attempt ends with a one-cycle transmit interrupt, whether the frame went out or was rejected. After a successful send the count register reads back as zero. After a rejection it keeps the written value, so software can see which frame failed. The transmit buffer sits at byte offset 4096 of a shared buffer window, after two receive buffers, and the block drives that window's read port with a fixed one-cycle read latency.

Top module: `tx_frame_launcher`

## Requirements
- R1: A count write with a nonzero value while the block is idle stores the value and starts an attempt. A write of zero stores zero and starts nothing: no interrupt and no output bytes.
- R2: A count below 64 or above 1530 is rejected. No byte is sent, and the count register keeps the written value.
- R3: Buffer bytes 0 to 6 must each be 0x55 and byte 7 must be 0xD5. Any other value rejects the frame, no byte is sent, and the count register keeps the written value.
- R4: On success, exactly count − 12 bytes are streamed, taken in order from buffer offset 8. The last flag is high on the final byte only.
- R5: After the final byte of a successful send has been accepted, the count register reads back 0.
- R6: Each triggered attempt, successful or rejected, produces exactly one `tx_irq` pulse lasting one clock cycle.
- R7: Every buffer read address lies in the transmit buffer, byte range 4096 to 6143 of the window. The byte at transmit-buffer offset k is read at window address 4096 + k.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R9: A count write during an attempt is ignored: the stream, the interrupt count and the final count value are unaffected.
- R10: After reset the count reads 0, and `tx_valid` and `tx_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_we | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 16 | Count value written |
| cnt_q | output | 16 | Count register read-back |
| buf_rd_en | output | 1 | Buffer RAM read enable |
| buf_rd_addr | output | 13 | Buffer window byte address |
| buf_rd_data | input | 8 | Read data, valid one cycle after `buf_rd_en` |
| tx_data | output | 8 | Output stream byte |
| tx_valid | output | 1 | Output byte valid |
| tx_last | output | 1 | Marks the final byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_irq | output | 1 | One-cycle pulse at the end of every attempt |

## Verification
The assertions assume that the buffer RAM returns data exactly one cycle after a read request. They also assume that the sink may stall at any time but never needs `tx_valid` to drop on its own. The bench models the RAM with that fixed latency and toggles `tx_ready` at random. The buffer contents stay frozen from the count write until the interrupt, so the expected bytes match what the block reads. Frame lengths are drawn around both limits. Preamble corruption is injected at chosen byte positions.

// File: rtl/tx_frame_launcher.sv
module tx_frame_launcher #(
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 13,
  parameter int TX_BASE   = 4096,
  parameter int BUF_BYTES = 2048,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1530
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              buf_rd_en,
  output logic [ADDR_W-1:0] buf_rd_addr,
  input  logic [7:0]        buf_rd_data,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              tx_irq
);
  localparam int IDX_W   = $clog2(BUF_BYTES);
  localparam int PRE_LEN = 8;
  localparam int FCS_LEN = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_PRD, S_PCMP, S_BRD, S_BLD, S_OUT, S_DONE
  } state_t;

  state_t            state;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        pre_exp;
  logic [CNT_W-1:0]  last_pos;
  logic              len_bad;
  logic              is_last;

  assign pre_exp     = (idx == IDX_W'(PRE_LEN - 1)) ? 8'hD5 : 8'h55;
  assign last_pos    = cnt_q - CNT_W'(FCS_LEN + 1);
  assign is_last     = (CNT_W'(idx) == last_pos);
  assign len_bad     = (cnt_q < CNT_W'(MIN_LEN)) || (cnt_q > CNT_W'(MAX_LEN));
  assign buf_rd_en   = (state == S_PRD) || (state == S_BRD);
  assign buf_rd_addr = ADDR_W'(TX_BASE) + ADDR_W'(idx);
  assign tx_irq      = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      cnt_q    <= '0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cnt_we) begin
          cnt_q <= cnt_wdata;
          if (cnt_wdata != '0) state <= S_CHK;
        end
        S_CHK: begin
          idx   <= '0;
          state <= len_bad ? S_DONE : S_PRD;
        end
        S_PRD: state <= S_PCMP;
        S_PCMP: begin
          if (buf_rd_data != pre_exp) state <= S_DONE;
          else begin
            idx   <= idx + 1'b1;
            state <= (idx == IDX_W'(PRE_LEN - 1)) ? S_BRD : S_PRD;
          end
        end
        S_BRD: state <= S_BLD;
        S_BLD: begin
          tx_data  <= buf_rd_data;
          tx_last  <= is_last;
          tx_valid <= 1'b1;
          state    <= S_OUT;
        end
        S_OUT: if (tx_ready) begin
          tx_valid <= 1'b0;
          if (tx_last) begin
            cnt_q <= '0;
            state <= S_DONE;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_BRD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R8
  AST_LEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (cnt_q >= CNT_W'(MIN_LEN) && cnt_q <= CNT_W'(MAX_LEN))); // R2
  AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> (cnt_q == '0 && tx_irq)); // R5
  AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |-> (buf_rd_addr >= ADDR_W'(TX_BASE) &&
                   buf_rd_addr < ADDR_W'(TX_BASE + BUF_BYTES))); // R7
endmodule

// File: tb/tx_frame_launcher_bench.sv
module tx_frame_launcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic [15:0] cnt_q;
  logic        buf_rd_en;
  logic [12:0] buf_rd_addr;
  logic [7:0]  buf_rd_data;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_ready, tx_irq;

  always #2.5 clk = ~clk;

  tx_frame_launcher u_tx_frame_launcher (
    .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cnt_q(cnt_q), .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr),
    .buf_rd_data(buf_rd_data), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready), .tx_irq(tx_irq));

  logic [7:0] mem [0:2047];
  logic [7:0] rx [0:2047];
  int rx_n, irq_n, last_pos_seen, last_cnt, addr_bad, stall_bad;
  int checks = 0, errors = 0;
  bit done = 0;
  logic p_valid, p_ready, p_last;
  logic [7:0] p_data;

  // RAM model, one-cycle read latency; R7 address check
  always_ff @(posedge clk) begin
    if (buf_rd_en) begin
      if (buf_rd_addr < 13'd4096 || buf_rd_addr >= 13'd6144) addr_bad <= addr_bad + 1;
      buf_rd_data <= mem[buf_rd_addr[10:0]];
    end
  end

  initial tx_ready = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_valid && !p_ready &&
          (!tx_valid || tx_data !== p_data || tx_last !== p_last)) stall_bad++;
      tx_ready = ($urandom_range(3) != 0);
      if (tx_irq) irq_n++;
      if (tx_valid && tx_ready) begin
        rx[rx_n] = tx_data;
        if (tx_last) begin last_pos_seen = rx_n; last_cnt++; end
        rx_n++;
      end
      p_valid = tx_valid; p_ready = tx_ready; p_data = tx_data; p_last = tx_last;
    end else begin
      p_valid = 1'b0; p_ready = 1'b0; p_data = '0; p_last = 1'b0;
    end
  end

  function automatic bit exp_ok(int len, int bad_pos);
    return (len >= 64) && (len <= 1530) && (bad_pos < 0);
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic write_cnt(int v);
    @(negedge clk);
    cnt_we = 1'b1; cnt_wdata = 16'(v);
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic fill(int len, int bad_pos);
    for (int i = 0; i < 2048; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 8; i++) mem[i] = (i == 7) ? 8'hD5 : 8'h55;
    if (bad_pos >= 0) mem[bad_pos] = mem[bad_pos] ^ 8'h10;
  endtask

  task automatic run_frame(int len, int bad_pos, int busy_write, string tag);
    int mism = 0;
    int body;
    bit ok;
    ok = exp_ok(len, bad_pos);
    body = ok ? len - 12 : 0;
    fill(len, bad_pos);
    rx_n = 0; irq_n = 0; last_cnt = 0; last_pos_seen = -1;
    write_cnt(len);
    if (busy_write > 0) begin
      repeat (busy_write) @(negedge clk);
      write_cnt(77);
    end
    for (int t = 0; t < 20000 && irq_n == 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(irq_n == 1, {tag, " R6 irq pulses"}, irq_n, 1);
    check(rx_n == body, {tag, " R4 byte count"}, rx_n, body);
    for (int i = 0; i < body && i < rx_n; i++) if (rx[i] !== mem[8 + i]) mism++;
    check(mism == 0, {tag, " R4 byte content"}, mism, 0);
    if (ok) begin
      check(last_cnt == 1 && last_pos_seen == body - 1, {tag, " R4 last flag"}, last_pos_seen, body - 1);
      check(cnt_q == 0, {tag, " R5 count cleared"}, cnt_q, 0);
    end else begin
      check(cnt_q == 16'(len), {tag, " R2 R3 count kept"}, cnt_q, len);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    addr_bad = 0; stall_bad = 0; rx_n = 0; irq_n = 0; last_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cnt_q == 0, "R10 reset count", cnt_q, 0);
    check(!tx_valid, "R10 reset valid", tx_valid, 0);
    check(!tx_irq, "R10 reset irq", tx_irq, 0);

    run_frame(64, -1, 0, "R1 min frame");
    run_frame(63, -1, 0, "R2 undersize");
    run_frame(1531, -1, 0, "R2 oversize");
    run_frame(1530, -1, 0, "R4 max frame");
    run_frame(100, 7, 0, "R3 bad SFD");
    run_frame(100, 2, 0, "R3 bad preamble");
    run_frame(100, -1, 40, "R9 busy write");
    for (int k = 0; k < 6; k++) begin
      int len;
      len = 56 + int'($urandom_range(250));
      run_frame(len, ($urandom_range(3) == 0) ? int'($urandom_range(7)) : -1, 0, "R4 random");
    end

    // R1: zero write stores only
    irq_n = 0; rx_n = 0;
    write_cnt(0);
    repeat (30) @(negedge clk);
    check(irq_n == 0 && rx_n == 0, "R1 zero write idle", irq_n + rx_n, 0);
    check(cnt_q == 0, "R1 zero stored", cnt_q, 0);

    check(addr_bad == 0, "R7 read window", addr_bad, 0);
    check(stall_bad == 0, "R8 stall hold", stall_bad, 0);
    done = 1;
    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end
endmodule